// File: doc/BRIEF.md
# Fetch Address Sequencer

This block owns the program counter of a simple 32-bit processor core and picks the next fetch address every cycle. The PC presented on `fetch_addr` is the byte address of the instruction word the core is executing. The same cycle, that word comes back on `instr`, together with the value of its first source register (`rs_val`) and a flag from the register compare logic saying whether its two operands match (`ops_equal`). From these the block computes the next PC. That next PC is one of five things: the following word, a taken PC-relative branch, a pseudo-direct jump, a register-indirect jump, or a hold when the register target is misaligned.

Instructions arrive as a stream qualified by `instr_vld`. The block has no ready output because it never applies back-pressure: a word offered with `instr_vld` high is consumed on that clock edge. When `instr_vld` is low the PC holds, and the link and fault outputs stay quiet. A subroutine call also raises a one-cycle write request for the link register. The request carries the return address, and the register file is expected to accept it in the same cycle.

Top module: `pcseq_top`

## Requirements
- R1: A synchronous active-high `rst` loads `fetch_addr` with the parameter START_ADDR (default 0x0040_0000). Out of reset, `fetch_addr` always has its two low bits at zero.
- R2: An accepted instruction that is not a branch, jump or register jump advances the PC by exactly 4. A load with opcode 35 is one example.
- R3: Opcode 4 (bits 31:26) branches when `ops_equal` is 1, and goes to PC+4 when it is 0.
- R4: Opcode 5 branches when `ops_equal` is 0, and goes to PC+4 when it is 1.
- R5: A taken branch goes to (PC+4) + (sign-extended bits 15:0 shifted left by 2). This covers the most negative offset 0x8000 and the largest positive offset 0x7FFF.
- R6: Opcode 2 jumps to {bits 31:28 of PC+4, instruction bits 25:0, 2'b00}. The upper four bits come from the incremented PC, so a jump placed at the last word of a 256 MB region lands in the next region.
- R7: Opcode 3 jumps like R6. In the same cycle it raises `link_we` for exactly that cycle, with `link_addr` = 31 and `link_data` = PC+4.
- R8: `link_we` is 0 for every instruction other than opcode 3, and while `instr_vld` is low or `rst` is high.
- R9: Opcode 0 with function code 8 (bits 5:0) loads the PC from `rs_val` when `rs_val[1:0]` is 0.
- R10: A register jump whose `rs_val[1:0]` is not zero raises `jr_misalign` in that cycle and leaves the PC unchanged.
- R11: While `instr_vld` is low, the PC holds and `link_we` and `jr_misalign` are 0, whatever `instr` carries.
- R12: Opcode 0 with any function code other than 8 is sequential. Function code 9 is one example.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_vld | input | 1 | `instr`, `rs_val` and `ops_equal` are valid and are consumed this cycle |
| instr | input | 32 | Instruction word fetched from `fetch_addr` |
| rs_val | input | 32 | Value of the register named in bits 25:21 |
| ops_equal | input | 1 | The two source operands of the instruction are equal |
| fetch_addr | output | 32 | Current program counter, byte address |
| link_we | output | 1 | Link register write request, one cycle per call |
| link_addr | output | 5 | Link register index (31) |
| link_data | output | 32 | Return address, PC+4 |
| jr_misalign | output | 1 | Register jump target has non-zero low bits |

## Verification
The properties assume that `instr` is the word stored at the current `fetch_addr`. They also assume that `rs_val` and `ops_equal` belong to that same word and are valid whenever `instr_vld` is high, and that START_ADDR is word aligned. The bench keeps to these assumptions by driving the instruction, operand and flag together on the falling edge. The bench walks a vector table whose expected addresses were worked out from the current PC of each step. Every register-jump value in the table is either aligned on purpose or misaligned on purpose.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned OFS_W   = 16;
  localparam int unsigned IDX_W   = 26;
  localparam int unsigned RIDX_W  = 5;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JMP     = 6'd2;
  localparam logic [OPC_W-1:0] OPC_CALL    = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'd5;
  localparam logic [FN_W-1:0]  FN_REGJMP   = 6'd8;

  typedef enum logic [2:0] {
    NXT_SEQ  = 3'd0,
    NXT_BR   = 3'd1,
    NXT_JMP  = 3'd2,
    NXT_REG  = 3'd3,
    NXT_HOLD = 3'd4
  } nxt_kind_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] src_a;
    logic [RIDX_W-1:0] src_b;
    logic [OFS_W-1:0]  imm;
  } ifmt_s;

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
(
  input  logic               vld,
  input  logic [INSTR_W-1:0] instr,
  input  logic               ops_equal,
  input  logic [1:0]         tgt_low,
  output nxt_kind_e          kind,
  output logic               is_call,
  output logic               misalign
);

  ifmt_s            f;
  logic [FN_W-1:0]  fn;
  logic             br_take;
  logic             is_regjmp;

  assign f  = ifmt_s'(instr);
  assign fn = instr[FN_W-1:0];

  // R3, R4: condition selected by opcode
  always_comb begin
    br_take = 1'b0;
    if (f.opc == OPC_BR_EQ) br_take = ops_equal;
    if (f.opc == OPC_BR_NE) br_take = ~ops_equal;
  end

  assign is_regjmp = (f.opc == OPC_SPECIAL) && (fn == FN_REGJMP);

  always_comb begin
    kind     = NXT_SEQ;
    is_call  = 1'b0;
    misalign = 1'b0;
    if (vld) begin
      if (br_take) begin
        kind = NXT_BR;
      end else if (f.opc == OPC_JMP || f.opc == OPC_CALL) begin
        kind    = NXT_JMP;
        is_call = (f.opc == OPC_CALL);
      end else if (is_regjmp) begin
        if (tgt_low != 2'b00) begin
          kind     = NXT_HOLD;
          misalign = 1'b1;
        end else begin
          kind = NXT_REG;
        end
      end
    end else begin
      kind = NXT_HOLD;
    end
  end

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  pc,
  input  logic [INSTR_W-1:0] instr,
  output logic [ADDR_W-1:0]  pc_inc,
  output logic [ADDR_W-1:0]  br_tgt,
  output logic [ADDR_W-1:0]  jmp_tgt
);

  localparam int unsigned HI_W  = ADDR_W - IDX_W - 2;
  localparam int unsigned EXT_W = ADDR_W - OFS_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [OFS_W-1:0]  ofs;
  logic [ADDR_W-1:0] ofs_bytes;

  assign ofs    = instr[OFS_W-1:0];
  assign pc_inc = pc + STEP;

  // R5: sign-extended word offset turned into bytes
  assign ofs_bytes = {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
  assign br_tgt    = pc_inc + ofs_bytes;

  // R6: region bits come from the incremented PC
  generate
    if (HI_W > 0) begin : g_region
      assign jmp_tgt = {pc_inc[ADDR_W-1 -: HI_W], instr[IDX_W-1:0], 2'b00};
    end else begin : g_flat
      assign jmp_tgt = {instr[ADDR_W-3:0], 2'b00};
    end
  endgenerate

endmodule

// File: rtl/pcseq_nextsel.sv
module pcseq_nextsel
  import pcseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  nxt_kind_e          kind,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [ADDR_W-1:0]  pc_inc,
  input  logic [ADDR_W-1:0]  br_tgt,
  input  logic [ADDR_W-1:0]  jmp_tgt,
  input  logic [ADDR_W-1:0]  reg_tgt,
  output logic [ADDR_W-1:0]  pc_nxt
);

  always_comb begin
    unique case (kind)
      NXT_BR:   pc_nxt = br_tgt;
      NXT_JMP:  pc_nxt = jmp_tgt;
      NXT_REG:  pc_nxt = reg_tgt;
      NXT_HOLD: pc_nxt = pc;
      default:  pc_nxt = pc_inc;
    endcase
  end

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter logic [31:0] START_ADDR = 32'h0040_0000,
  parameter int unsigned LINK_REG   = 31
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      instr_vld,
  input  logic [INSTR_W-1:0]        instr,
  input  logic [ADDR_W-1:0]         rs_val,
  input  logic                      ops_equal,
  output logic [ADDR_W-1:0]         fetch_addr,
  output logic                      link_we,
  output logic [RIDX_W-1:0]         link_addr,
  output logic [ADDR_W-1:0]         link_data,
  output logic                      jr_misalign
);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_nxt;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] br_tgt;
  logic [ADDR_W-1:0] jmp_tgt;
  nxt_kind_e         kind;
  logic              is_call;
  logic              mis;

  pcseq_decode u_dec (
    .vld       (instr_vld),
    .instr     (instr),
    .ops_equal (ops_equal),
    .tgt_low   (rs_val[1:0]),
    .kind      (kind),
    .is_call   (is_call),
    .misalign  (mis)
  );

  pcseq_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc      (pc_q),
    .instr   (instr),
    .pc_inc  (pc_inc),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt)
  );

  pcseq_nextsel #(.ADDR_W(ADDR_W)) u_sel (
    .kind    (kind),
    .pc      (pc_q),
    .pc_inc  (pc_inc),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt),
    .reg_tgt (rs_val),
    .pc_nxt  (pc_nxt)
  );

  // R1: synchronous restart
  always_ff @(posedge clk) begin
    if (rst) pc_q <= ADDR_W'(START_ADDR);
    else     pc_q <= pc_nxt;
  end

  assign fetch_addr  = pc_q;
  // R7, R8: call link request, quiet in reset
  assign link_we     = is_call & ~rst;
  assign link_addr   = RIDX_W'(LINK_REG);
  assign link_data   = pc_inc;
  // R10
  assign jr_misalign = mis & ~rst;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_vld,
  input logic [31:0]       instr,
  input logic [ADDR_W-1:0] rs_val,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              link_we,
  input logic [4:0]        link_addr,
  input logic [ADDR_W-1:0] link_data,
  input logic              jr_misalign
);

  logic [5:0]        op;
  logic              regjmp;
  logic              plain;
  logic [ADDR_W-1:0] nxt_word;
  logic [ADDR_W-1:0] far_tgt;

  assign op       = instr[31:26];
  assign regjmp   = (op == 6'd0) && (instr[5:0] == 6'd8);
  assign plain    = !regjmp && op != 6'd2 && op != 6'd3 && op != 6'd4 && op != 6'd5;
  assign nxt_word = fetch_addr + 32'd4;
  assign far_tgt  = {nxt_word[31:28], instr[25:0], 2'b00};

  // R1
  reset_start_chk: assert property (@(posedge clk)
    rst |=> fetch_addr == ADDR_W'(START_ADDR));

  // R1
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_addr[1:0] == 2'b00);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    instr_vld && plain |=> fetch_addr == $past(nxt_word));

  // R6
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    instr_vld && op == 6'd2 |=> fetch_addr == $past(far_tgt));

  // R7
  link_payload_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_addr == 5'd31 && link_data == nxt_word);

  // R8
  link_only_call_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> instr_vld && op == 6'd3);

  // R9
  reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
    instr_vld && regjmp && rs_val[1:0] == 2'b00 |=> fetch_addr == $past(rs_val));

  // R10
  misalign_hold_chk: assert property (@(posedge clk) disable iff (rst)
    jr_misalign |=> $stable(fetch_addr));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_vld |=> $stable(fetch_addr));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_vld |-> !link_we && !jr_misalign);

endmodule

bind pcseq_top pcseq_chk #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .instr_vld   (instr_vld),
  .instr       (instr),
  .rs_val      (rs_val),
  .fetch_addr  (fetch_addr),
  .link_we     (link_we),
  .link_addr   (link_addr),
  .link_data   (link_data),
  .jr_misalign (jr_misalign)
);

// File: tb/pcseq_tb.sv
module pcseq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] START = 32'h0040_0000;

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] rsv;
    logic        eq;
    logic [31:0] exp_pc;
    logic        exp_lnk;
    logic [31:0] exp_ldat;
    logic        exp_mis;
    logic [7:0]  req;
  } vec_s;

  localparam int NV = 18;
  localparam vec_s VT [NV] = '{
    // R12: op 0 funct 0x20 at 00400000 -> +4
    '{32'h0232_4820, 32'h0, 1'b0, 32'h0040_0004, 1'b0, 32'h0, 1'b0, 8'd12},
    // R3 R5: beq +3 taken at 00400004
    '{32'h1000_0003, 32'h0, 1'b1, 32'h0040_0014, 1'b0, 32'h0, 1'b0, 8'd3},
    // R3: beq not taken
    '{32'h1000_0005, 32'h0, 1'b0, 32'h0040_0018, 1'b0, 32'h0, 1'b0, 8'd3},
    // R4 R5: bne -2 taken at 00400018
    '{32'h1400_FFFE, 32'h0, 1'b0, 32'h0040_0014, 1'b0, 32'h0, 1'b0, 8'd4},
    // R4: bne not taken
    '{32'h1400_0007, 32'h0, 1'b1, 32'h0040_0018, 1'b0, 32'h0, 1'b0, 8'd4},
    // R6: j
    '{32'h0810_0040, 32'h0, 1'b0, 32'h0040_0100, 1'b0, 32'h0, 1'b0, 8'd6},
    // R7: jal at 00400100
    '{32'h0C10_0080, 32'h0, 1'b0, 32'h0040_0200, 1'b1, 32'h0040_0104, 1'b0, 8'd7},
    // R9: jr aligned
    '{32'h03E0_0008, 32'h0040_0030, 1'b0, 32'h0040_0030, 1'b0, 32'h0, 1'b0, 8'd9},
    // R10: jr misaligned holds
    '{32'h03E0_0008, 32'h0040_0032, 1'b0, 32'h0040_0030, 1'b0, 32'h0, 1'b1, 8'd10},
    // R2 R8: load word
    '{32'h8C08_0020, 32'h0, 1'b1, 32'h0040_0034, 1'b0, 32'h0, 1'b0, 8'd2},
    // R12: op 0 funct 9 sequential
    '{32'h0000_0009, 32'h0, 1'b0, 32'h0040_0038, 1'b0, 32'h0, 1'b0, 8'd12},
    // R9: jr to high region
    '{32'h0000_0008, 32'hF000_0000, 1'b0, 32'hF000_0000, 1'b0, 32'h0, 1'b0, 8'd9},
    // R6: keeps region F
    '{32'h0800_0010, 32'h0, 1'b0, 32'hF000_0040, 1'b0, 32'h0, 1'b0, 8'd6},
    // R5: most negative offset
    '{32'h1000_8000, 32'h0, 1'b1, 32'hEFFE_0044, 1'b0, 32'h0, 1'b0, 8'd5},
    // R7: jal max index at EFFE0044
    '{32'h0FFF_FFFF, 32'h0, 1'b0, 32'hEFFF_FFFC, 1'b1, 32'hEFFE_0048, 1'b0, 8'd7},
    // R9: jr to last word of region 0
    '{32'h0000_0008, 32'h0FFF_FFFC, 1'b1, 32'h0FFF_FFFC, 1'b0, 32'h0, 1'b0, 8'd9},
    // R6: region from incremented PC -> 1
    '{32'h0800_0000, 32'h0, 1'b0, 32'h1000_0000, 1'b0, 32'h0, 1'b0, 8'd6},
    // R5: largest positive offset
    '{32'h1400_7FFF, 32'h0, 1'b0, 32'h1002_0000, 1'b0, 32'h0, 1'b0, 8'd5}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_vld;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic        ops_equal;
  logic [31:0] fetch_addr;
  logic        link_we;
  logic [4:0]  link_addr;
  logic [31:0] link_data;
  logic        jr_misalign;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcseq_top #(.START_ADDR(START)) dut_i (
    .clk(clk), .rst(rst), .instr_vld(instr_vld), .instr(instr),
    .rs_val(rs_val), .ops_equal(ops_equal), .fetch_addr(fetch_addr),
    .link_we(link_we), .link_addr(link_addr), .link_data(link_data),
    .jr_misalign(jr_misalign)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] i,
                       input logic [31:0] r, input logic e);
    instr_vld = v; instr = i; rs_val = r; ops_equal = e;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 32'h0, 32'h0, 1'b0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "fetch_addr in reset", fetch_addr, START);
    check("R8", "link_we in reset", {31'b0, link_we}, 32'h0);
    rst = 1'b0;

    // R11: invalid call word is ignored
    drive(1'b0, 32'h0C00_0010, 32'h0, 1'b0);
    #1;
    check("R11", "link_we while idle", {31'b0, link_we}, 32'h0);
    @(negedge clk);
    check("R11", "pc held while idle", fetch_addr, START);
    // R11: invalid misaligned jr is ignored
    drive(1'b0, 32'h0000_0008, 32'h0000_0003, 1'b0);
    #1;
    check("R11", "misalign while idle", {31'b0, jr_misalign}, 32'h0);
    @(negedge clk);
    check("R11", "pc held after idle jr", fetch_addr, START);

    for (int k = 0; k < NV; k++) begin
      string rq;
      rq = $sformatf("R%0d", VT[k].req);
      drive(1'b1, VT[k].ins, VT[k].rsv, VT[k].eq);
      #1;
      check(rq, "link_we", {31'b0, link_we}, {31'b0, VT[k].exp_lnk});
      check(rq, "jr_misalign", {31'b0, jr_misalign}, {31'b0, VT[k].exp_mis});
      if (VT[k].exp_lnk) begin
        check("R7", "link_data", link_data, VT[k].exp_ldat);
        check("R7", "link_addr", {27'b0, link_addr}, 32'd31);
      end
      @(negedge clk);
      check(rq, "next pc", fetch_addr, VT[k].exp_pc);
    end

    // R1: reset mid-run restores start address
    drive(1'b1, 32'h0C00_0010, 32'h0, 1'b0);
    rst = 1'b1;
    #1;
    check("R8", "link_we under reset", {31'b0, link_we}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "pc after mid-run reset", fetch_addr, START);
    // R7: one-cycle link then gone
    drive(1'b1, 32'h0C00_0010, 32'h0, 1'b0);
    #1;
    check("R7", "link_we on call", {31'b0, link_we}, 32'h1);
    @(negedge clk);
    check("R7", "call target", fetch_addr, 32'h0000_0040);
    drive(1'b0, 32'h0C00_0010, 32'h0, 1'b0);
    #1;
    check("R7", "link_we dropped", {31'b0, link_we}, 32'h0);
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule